// File: doc/BRIEF.md
# UART Receive Buffer with Watermark Flow Control

This block sits between a UART receiver and an upstream consumer that drains data in bursts. Each received character, or each received line-break condition, becomes one entry in a bounded ring buffer. The upstream side sees the head entry and pops it with a single-cycle strobe. A break is stored as a tagged entry, so its position in the stream relative to the data around it is kept.

The RTS output tells the remote transmitter whether it may send. It uses two watermarks with hysteresis. RTS drops when the fill level reaches the high mark. It comes back only after the level falls below the low mark. If the remote side ignores RTS and the buffer is full, each further arrival is dropped. Every drop produces a one-cycle event pulse and is counted. A pop on an empty buffer is also counted, as an underrun. Both counters saturate and are cleared by a pulse.

The outgoing direction has a CTS gate. A byte offered by the upstream side starts transmission only while the synchronised CTS input is active and the UART transmitter is idle. A frame that has already started is never interrupted.

Top module: `uart_rxbuf_bridge`

## Requirements
- R1: Stored entries leave in arrival order. `up_valid` is high exactly when `level` is non-zero, and `up_data`/`up_is_break` show the oldest entry.
- R2: A `rx_break` pulse stores an entry with `up_is_break`=1 and `up_data`=8'h00. If `rx_break` and `rx_valid` arrive together, only the break is stored.
- R3: An arrival while `level` equals DEPTH is dropped and leaves the stored contents unchanged. `drop_evt` is high for one cycle, in the cycle after the arrival edge.
- R4: `ovr_count` increments once per dropped arrival and saturates at all-ones.
- R5: `up_pop` while the buffer is empty changes no stored state, increments `udr_count`, and `udr_count` saturates at all-ones.
- R6: When `level` is at or above HI_WM at a clock edge, `rts_allow` is low after the next edge.
- R7: Once low, `rts_allow` rises only after an edge at which `level` was below LO_WM. While `level` is between the marks it holds its value. It is high out of reset.
- R8: CTS passes through a two-stage synchroniser that resets to inactive. `tx_start` (and `tx_in_ready`) is high only when `tx_in_valid` is high, `tx_busy` is low and the synchronised CTS is high. A frame in progress is never cut.
- R9: A `cnt_clr` pulse sets both counters to zero at the next edge, and takes priority over a simultaneous increment.
- R10: `level` reports the number of stored entries and never exceeds DEPTH. After reset it is 0 and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| rx_break | input | 1 | Received break-condition strobe |
| up_valid | output | 1 | Head entry present |
| up_data | output | 8 | Head entry byte |
| up_is_break | output | 1 | Head entry is a break marker |
| up_pop | input | 1 | Consume head entry |
| level | output | $clog2(DEPTH+1) | Stored entry count |
| rts_allow | output | 1 | Remote may send (high = go) |
| drop_evt | output | 1 | One-cycle pulse per dropped arrival |
| ovr_count | output | CNT_W | Saturating overrun count |
| udr_count | output | CNT_W | Saturating underrun count |
| cnt_clr | input | 1 | Clear both counters |
| cts_in | input | 1 | Asynchronous clear-to-send (high = go) |
| tx_in_valid | input | 1 | Upstream offers an outgoing byte |
| tx_in_data | input | 8 | Outgoing byte |
| tx_in_ready | output | 1 | Outgoing byte accepted this cycle |
| tx_busy | input | 1 | UART transmitter frame in progress |
| tx_start | output | 1 | Start a frame with tx_out_data |
| tx_out_data | output | 8 | Byte handed to the transmitter |

## Verification
The hardest behaviour to reach is the hysteresis band of RTS. Reaching it means filling past the high mark and then draining to exactly the low mark, where RTS must still be low, and then one entry further. The bench fills the buffer to DEPTH with numbered bytes and keeps pushing into the full buffer to provoke drops. It then pops one entry at a time and checks RTS at each mark. The same drain confirms that the dropped bytes did not disturb the stored sequence. Counter saturation is reached by hundreds of pops on an empty buffer.

// File: rtl/rxb_pkg.sv
// Package: shared entry type for the UART receive buffer.
// Assumes 8-bit characters; a break is carried by the tag bit.
package rxb_pkg;
    typedef struct packed {
        logic       brk;
        logic [7:0] val;
    } rxb_entry_t;
endpackage

// File: rtl/rxb_ring.sv
// Ring storage with occupancy level. Writes when full and reads when
// empty are refused here; the caller accounts for them.
// Assumes DEPTH >= 2.
module rxb_ring #(
    parameter int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  rxb_pkg::rxb_entry_t    wr_entry,
    input  logic                   rd_en,
    output rxb_pkg::rxb_entry_t    rd_entry,
    output logic [LVL_W-1:0]       level,
    output logic                   full,
    output logic                   empty
);
    rxb_pkg::rxb_entry_t mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic wr_acc, rd_acc;

    assign full   = (level == LVL_W'(DEPTH));
    assign empty  = (level == '0);
    assign wr_acc = wr_en && !full;
    assign rd_acc = rd_en && !empty;
    assign rd_entry = mem[rd_ptr];

    // Storage write.
    always_ff @(posedge clk) begin
        if (wr_acc) mem[wr_ptr] <= wr_entry;
    end

    // Pointer advance with wrap, and level tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (wr_acc) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (rd_acc) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (wr_acc && !rd_acc)      level <= level + 1'b1;
            else if (rd_acc && !wr_acc) level <= level - 1'b1;
        end
    end
endmodule

// File: rtl/rxb_sat_cnt.sv
// Saturating event counter with synchronous clear; clear beats increment.
module rxb_sat_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    // Count up to all-ones and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)         count <= '0;
        else if (inc && count != '1) count <= count + 1'b1;
    end
endmodule

// File: rtl/rxb_flow.sv
// Flow control: RTS from level with hysteresis between two marks, and a
// CTS gate for the outgoing direction. CTS is asynchronous and is
// synchronised here; starts happen only between frames.
// Assumes LO_WM <= HI_WM <= DEPTH.
module rxb_flow #(
    parameter int LVL_W = 5,
    parameter int HI_WM = 12,
    parameter int LO_WM = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    output logic             rts_allow,
    input  logic             cts_in,
    input  logic             tx_in_valid,
    input  logic             tx_busy,
    output logic             tx_start
);
    logic cts_s1, cts_s2;

    // RTS hysteresis: stop at the high mark, resume below the low mark.
    always_ff @(posedge clk) begin
        if (!rst_n)                          rts_allow <= 1'b1;
        else if (level >= LVL_W'(HI_WM))     rts_allow <= 1'b0;
        else if (level <  LVL_W'(LO_WM))     rts_allow <= 1'b1;
    end

    // Two-stage CTS synchroniser, inactive out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cts_s1 <= 1'b0;
            cts_s2 <= 1'b0;
        end else begin
            cts_s1 <= cts_in;
            cts_s2 <= cts_s1;
        end
    end

    // A frame may start only when idle and cleared to send.
    always_comb tx_start = tx_in_valid && !tx_busy && cts_s2;
endmodule

// File: rtl/uart_rxbuf_bridge.sv
// UART receive buffer for a burst-served upstream consumer. Characters
// and break markers share one bounded ring; overflow drops the arrival
// with an event pulse, and overruns/underruns are counted.
// Assumes rx strobes are single-cycle and already in the clk domain.
module uart_rxbuf_bridge #(
    parameter int DEPTH = 16,
    parameter int HI_WM = 12,
    parameter int LO_WM = 4,
    parameter int CNT_W = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_break,
    output logic             up_valid,
    output logic [7:0]       up_data,
    output logic             up_is_break,
    input  logic             up_pop,
    output logic [LVL_W-1:0] level,
    output logic             rts_allow,
    output logic             drop_evt,
    output logic [CNT_W-1:0] ovr_count,
    output logic [CNT_W-1:0] udr_count,
    input  logic             cnt_clr,
    input  logic             cts_in,
    input  logic             tx_in_valid,
    input  logic [7:0]       tx_in_data,
    output logic             tx_in_ready,
    input  logic             tx_busy,
    output logic             tx_start,
    output logic [7:0]       tx_out_data
);
    localparam int N_EV = 2;

    rxb_pkg::rxb_entry_t in_entry, head;
    logic push, full, empty;
    logic [N_EV-1:0] ev;
    logic [CNT_W-1:0] cnt [N_EV];

    // Build the incoming entry; a break wins over a simultaneous character.
    always_comb begin
        push = rx_valid || rx_break;
        in_entry.brk = rx_break;
        in_entry.val = rx_break ? 8'h00 : rx_data;
    end

    rxb_ring #(.DEPTH(DEPTH)) i_ring (
        .clk(clk), .rst_n(rst_n),
        .wr_en(push), .wr_entry(in_entry),
        .rd_en(up_pop), .rd_entry(head),
        .level(level), .full(full), .empty(empty)
    );

    assign up_valid    = !empty;
    assign up_data     = head.val;
    assign up_is_break = head.brk;

    // Event 0 is an overrun (arrival while full), event 1 an underrun.
    assign ev[0] = push && full;
    assign ev[1] = up_pop && empty;

    // Drop pulse, registered from the overrun event.
    always_ff @(posedge clk) begin
        if (!rst_n) drop_evt <= 1'b0;
        else        drop_evt <= ev[0];
    end

    for (genvar g = 0; g < N_EV; g++) begin : g_cnt
        rxb_sat_cnt #(.W(CNT_W)) i_cnt (
            .clk(clk), .rst_n(rst_n), .clr(cnt_clr),
            .inc(ev[g]), .count(cnt[g])
        );
    end

    assign ovr_count = cnt[0];
    assign udr_count = cnt[1];

    rxb_flow #(.LVL_W(LVL_W), .HI_WM(HI_WM), .LO_WM(LO_WM)) i_flow (
        .clk(clk), .rst_n(rst_n), .level(level), .rts_allow(rts_allow),
        .cts_in(cts_in), .tx_in_valid(tx_in_valid), .tx_busy(tx_busy),
        .tx_start(tx_start)
    );

    assign tx_in_ready = tx_start;
    assign tx_out_data = tx_in_data;
endmodule

// File: rtl/rxb_checker.sv
// Property checker for uart_rxbuf_bridge, bound to every instance.
module rxb_checker #(
    parameter int DEPTH = 16,
    parameter int HI_WM = 12,
    parameter int LO_WM = 4,
    parameter int CNT_W = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic             rx_break,
    input logic             up_pop,
    input logic [LVL_W-1:0] level,
    input logic             rts_allow,
    input logic             drop_evt,
    input logic [CNT_W-1:0] ovr_count,
    input logic [CNT_W-1:0] udr_count,
    input logic             cnt_clr,
    input logic             cts_in,
    input logic             tx_busy,
    input logic             tx_start
);
    p_level_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid || rx_break) && level == LVL_W'(DEPTH) |=> drop_evt && level == LVL_W'(DEPTH) || level == LVL_W'(DEPTH - 1));

    p_ovr_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid || rx_break) && level == LVL_W'(DEPTH) && !cnt_clr && ovr_count != '1
        |=> ovr_count - $past(ovr_count) == CNT_W'(1));

    p_udr_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        up_pop && level == '0 && !cnt_clr && udr_count != '1
        |=> udr_count - $past(udr_count) == CNT_W'(1));

    p_rts_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        level >= LVL_W'(HI_WM) |=> !rts_allow);

    p_rts_resume_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rts_allow |=> !rts_allow || $past(level) < LVL_W'(LO_WM));

    p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> !tx_busy);

    p_start_cts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> $past(cts_in, 2));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> ovr_count == '0 && udr_count == '0);
endmodule

bind uart_rxbuf_bridge rxb_checker #(
    .DEPTH(DEPTH), .HI_WM(HI_WM), .LO_WM(LO_WM), .CNT_W(CNT_W)
) i_rxb_checker (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_break(rx_break),
    .up_pop(up_pop), .level(level), .rts_allow(rts_allow),
    .drop_evt(drop_evt), .ovr_count(ovr_count), .udr_count(udr_count),
    .cnt_clr(cnt_clr), .cts_in(cts_in), .tx_busy(tx_busy),
    .tx_start(tx_start)
);

// File: tb/test_uart_rxbuf_bridge.sv
module test_uart_rxbuf_bridge;
    localparam int DEPTH = 16, HI_WM = 12, LO_WM = 4, CNT_W = 8;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic rx_valid = 0, rx_break = 0, up_pop = 0, cnt_clr = 0;
    logic [7:0] rx_data = 0, tx_in_data = 0;
    logic cts_in = 0, tx_in_valid = 0, tx_busy = 0;
    logic up_valid, up_is_break, rts_allow, drop_evt, tx_in_ready, tx_start;
    logic [7:0] up_data, tx_out_data;
    logic [LVL_W-1:0] level;
    logic [CNT_W-1:0] ovr_count, udr_count;
    int checks = 0, errors = 0, cycles = 0;

    always #4 clk = ~clk;  // 125 MHz

    uart_rxbuf_bridge #(.DEPTH(DEPTH), .HI_WM(HI_WM), .LO_WM(LO_WM), .CNT_W(CNT_W))
    i_uart_rxbuf_bridge (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_byte(input logic [7:0] b);
        rx_valid = 1; rx_data = b; @(negedge clk); rx_valid = 0;
    endtask

    task automatic push_break();
        rx_break = 1; @(negedge clk); rx_break = 0;
    endtask

    task automatic pop_chk(input int exp_d, input bit exp_b, input string req);
        check(up_valid == 1, req, up_valid, 1);
        check(up_data == exp_d[7:0], req, up_data, exp_d);
        check(up_is_break == exp_b, req, up_is_break, exp_b);
        up_pop = 1; @(negedge clk); up_pop = 0;
    endtask

    task automatic pop_raw();
        up_pop = 1; @(negedge clk); up_pop = 0;
    endtask

    task automatic t_reset();  // R10, R7, R8
        check(level == 0, "R10 level", level, 0);
        check(up_valid == 0, "R1 valid", up_valid, 0);
        check(rts_allow == 1, "R7 rts reset", rts_allow, 1);
        check(ovr_count == 0 && udr_count == 0, "R10 counters", ovr_count + udr_count, 0);
        check(tx_start == 0, "R8 start", tx_start, 0);
    endtask

    task automatic t_order_break();  // R1, R2
        push_byte(8'h41); push_break(); push_byte(8'h42);
        rx_valid = 1; rx_break = 1; rx_data = 8'h77; @(negedge clk);
        rx_valid = 0; rx_break = 0;
        check(level == 4, "R10 level", level, 4);
        pop_chk(8'h41, 0, "R1");
        pop_chk(8'h00, 1, "R2 break");
        pop_chk(8'h42, 0, "R1");
        pop_chk(8'h00, 1, "R2 break wins");
        check(up_valid == 0, "R1 empty", up_valid, 0);
    endtask

    task automatic t_fill_drain();  // R3, R4, R6, R7
        for (int i = 0; i < HI_WM - 1; i++) push_byte(8'(i + 1));
        idle(1);
        check(rts_allow == 1, "R6 below mark", rts_allow, 1);
        push_byte(8'(HI_WM)); idle(1);
        check(rts_allow == 0, "R6 at mark", rts_allow, 0);
        for (int i = HI_WM; i < DEPTH; i++) push_byte(8'(i + 1));
        check(level == DEPTH, "R10 full", level, DEPTH);
        for (int i = 0; i < 3; i++) begin
            push_byte(8'hEE);
            check(drop_evt == 1, "R3 drop pulse", drop_evt, 1);
            check(ovr_count == i + 1, "R4 count", ovr_count, i + 1);
        end
        push_break();
        check(drop_evt == 1, "R3 break drop", drop_evt, 1);
        idle(1);
        check(drop_evt == 0, "R3 one cycle", drop_evt, 0);
        check(ovr_count == 4 && level == DEPTH, "R4 R3 after drops", ovr_count, 4);
        for (int i = 0; i < DEPTH - LO_WM; i++) pop_chk(i + 1, 0, "R3 contents");
        idle(1);
        check(rts_allow == 0, "R7 hold at low mark", rts_allow, 0);
        pop_chk(DEPTH - LO_WM + 1, 0, "R3 contents");
        idle(1);
        check(rts_allow == 1, "R7 resume", rts_allow, 1);
        for (int i = DEPTH - LO_WM + 1; i < DEPTH; i++) pop_chk(i + 1, 0, "R3 contents");
        check(level == 0, "R10 drained", level, 0);
    endtask

    task automatic t_underrun_clear();  // R5, R9
        for (int i = 0; i < 3; i++) pop_raw();
        check(udr_count == 3 && level == 0, "R5 underrun", udr_count, 3);
        for (int i = 0; i < 300; i++) pop_raw();
        check(udr_count == 255, "R5 saturate", udr_count, 255);
        check(up_valid == 0, "R5 no state", up_valid, 0);
        up_pop = 1; cnt_clr = 1; @(negedge clk); up_pop = 0; cnt_clr = 0;
        check(udr_count == 0 && ovr_count == 0, "R9 clear", udr_count + ovr_count, 0);
    endtask

    task automatic t_cts();  // R8
        tx_in_valid = 1; tx_in_data = 8'h5A; cts_in = 0; idle(3);
        check(tx_start == 0, "R8 cts low", tx_start, 0);
        cts_in = 1; idle(1);
        check(tx_start == 0, "R8 sync stage", tx_start, 0);
        idle(1);
        check(tx_start == 1 && tx_in_ready == 1, "R8 go", tx_start, 1);
        check(tx_out_data == 8'h5A, "R8 data", tx_out_data, 8'h5A);
        tx_busy = 1; #1;
        check(tx_start == 0, "R8 busy", tx_start, 0);
        cts_in = 0; idle(3); tx_busy = 0; #1;
        check(tx_start == 0, "R8 paused", tx_start, 0);
        tx_in_valid = 0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        idle(3); rst_n = 1; idle(1);
        t_reset();
        t_order_break();
        t_fill_drain();
        t_underrun_clear();
        t_cts();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule